// File: doc/BRIEF.md
# Serial Frame Emitter

This block is a transmit station for a cut-down CAN-style data frame. A requester presents an 11-bit identifier, a remote-request flag, a 2-bit length code and a 16-bit payload on a valid/ready interface. The block captures the request, builds a fixed 44-bit frame from it, and sends that frame one bit at a time on a single serial line. Each pulse of `bit_en` moves the line to the next bit. The frame has no stuff bits. The only check code is one parity bit.

The frame goes out in this order: start (0), identifier, remote flag, format bit (0), reserved bit (0), length code, payload, parity bit, check delimiter (1), acknowledge slot (driven 1), acknowledge delimiter (1), and seven end bits (1). Within each field the most significant bit goes first. The parity bit is chosen so that the start bit, the fields through the payload and the parity bit together hold an even number of ones.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. The requester keeps `req_valid` high and may still change the payload while `req_ready` is low. Only the values present on the accepting edge are used. A state register that holds an encoding outside the legal set sends the block back to idle.

Top module: `ser_frame_tx`

## Requirements
- R1: While reset is held, and when idle after reset, `req_ready` is 1, `tx_bit` is 1 (recessive) and `tx_done` is 0.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` is 0, and it stays 0 until the final frame bit has been consumed.
- R3: A frame is exactly 44 bits. The start bit is 0. The format and reserved bits are 0. The check delimiter, acknowledge slot, acknowledge delimiter and all seven end bits are 1.
- R4: Bits are sent in this order: start, identifier[10:0], remote flag, format, reserved, length[1:0], payload[15:0], parity, delimiters, end bits. Each field goes out MSB first. The start bit is on the line in the cycle after acceptance.
- R5: The parity bit (bit 34 of the frame, counting from 1) is the XOR of frame bits 1 through 33.
- R6: Each `bit_en` pulse while sending replaces the line bit with the next frame bit. Without a pulse, the line holds its bit.
- R7: In the cycle after the edge that consumes the 44th bit, `tx_done` is 1 for exactly one cycle and `req_ready` is 1 again.
- R8: While `req_ready` is 0, `req_valid` and the request fields have no effect on the frame in flight. A held request is taken as soon as the block is idle, with the field values present on that edge.
- R9: When idle, `bit_en` pulses leave `tx_bit` at 1 and do not start a frame.
- R10: No stuff bits are inserted. An all-zero request sends 34 consecutive 0 bits (start through parity) and then 10 bits of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_id | input | 11 | Frame identifier |
| req_rtr | input | 1 | Remote-request flag |
| req_len | input | 2 | Length code |
| req_data | input | 16 | Payload |
| bit_en | input | 1 | Bit-time tick: move to the next bit |
| tx_bit | output | 1 | Serial line, 1 when idle |
| tx_done | output | 1 | One-cycle pulse after the final bit |

## Verification
The assertions check these local timing rules on every cycle:
- the line is recessive whenever the block is ready;
- `req_ready` drops after a handshake, and the start bit appears in the next cycle;
- the line holds its bit across cycles without a tick;
- `tx_done` lasts one cycle and coincides with a return to ready.

Only the bench scenarios show frame content and length. These cover field order, the parity value, the absence of stuffing, and that a request changed while held back is sent with its values from the accepting edge. A cycle-by-cycle model checks these under dense and sparse ticks.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  localparam logic LVL_DOM = 1'b0;
  localparam logic LVL_REC = 1'b1;

  typedef enum logic [1:0] {
    TX_IDLE = 2'b00,
    TX_SEND = 2'b01
  } tx_state_e;
endpackage

// File: rtl/frame_builder.sv
module frame_builder
  import ftx_pkg::*;
#(
  parameter int ID_W   = 11,
  parameter int LEN_W  = 2,
  parameter int DATA_W = 16,
  parameter int EOF_W  = 7,
  localparam int HEAD_W  = 1 + ID_W + 3 + LEN_W + DATA_W,
  localparam int FRAME_W = HEAD_W + 4 + EOF_W
) (
  input  logic [ID_W-1:0]    req_id,
  input  logic               req_rtr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [DATA_W-1:0]  req_data,
  output logic [FRAME_W-1:0] frame
);
  logic [HEAD_W-1:0] head;
  logic              parity;

  // start, id, remote flag, format, reserved, length, payload
  assign head   = {LVL_DOM, req_id, req_rtr, LVL_DOM, LVL_DOM, req_len, req_data};
  assign parity = ^head;
  // parity, check delimiter, ack slot, ack delimiter, end bits
  assign frame  = {head, parity, LVL_REC, LVL_REC, LVL_REC, {EOF_W{LVL_REC}}};
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
  import ftx_pkg::*;
#(
  parameter int FRAME_W = 44,
  localparam int CNT_W = $clog2(FRAME_W)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic bit_en,
  output logic req_ready,
  output logic load,
  output logic shift,
  output logic sending,
  output logic tx_done
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  tx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_d;

  assign req_ready = (state_q == TX_IDLE);
  assign sending   = (state_q == TX_SEND);
  assign load      = req_ready && req_valid;
  assign shift     = sending && bit_en && (cnt_q < LAST_IDX);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    case (state_q)
      TX_IDLE: begin
        if (req_valid) begin
          state_d = TX_SEND;
          cnt_d   = '0;
        end
      end
      TX_SEND: begin
        if (cnt_q > LAST_IDX) begin
          state_d = TX_IDLE;
          cnt_d   = '0;
        end else if (bit_en) begin
          if (cnt_q == LAST_IDX) begin
            state_d = TX_IDLE;
            cnt_d   = '0;
            done_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = TX_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      tx_done <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tx_done <= done_d;
    end
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import ftx_pkg::*;
#(
  parameter int FRAME_W = 44
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic [FRAME_W-1:0] frame,
  output logic               head_bit
);
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sh_q <= {FRAME_W{LVL_REC}};
    else if (load)
      sh_q <= frame;
    else if (shift)
      sh_q <= {sh_q[FRAME_W-2:0], LVL_REC};
  end

  assign head_bit = sh_q[FRAME_W-1];
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
  import ftx_pkg::*;
#(
  parameter int ID_W   = 11,
  parameter int LEN_W  = 2,
  parameter int DATA_W = 16,
  parameter int EOF_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_rtr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_data,
  input  logic              bit_en,
  output logic              tx_bit,
  output logic              tx_done
);
  localparam int FRAME_W = 1 + ID_W + 3 + LEN_W + DATA_W + 4 + EOF_W;

  logic [FRAME_W-1:0] frame;
  logic               load, shift, sending, head_bit;

  frame_builder #(
    .ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .EOF_W(EOF_W)
  ) u_build (
    .req_id(req_id), .req_rtr(req_rtr), .req_len(req_len),
    .req_data(req_data), .frame(frame)
  );

  tx_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bit_en(bit_en),
    .req_ready(req_ready), .load(load), .shift(shift),
    .sending(sending), .tx_done(tx_done)
  );

  tx_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
    .frame(frame), .head_bit(head_bit)
  );

  assign tx_bit = sending ? head_bit : LVL_REC;
endmodule

// File: rtl/ser_frame_tx_checker.sv
module ser_frame_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic bit_en,
  input logic tx_bit,
  input logic tx_done
);
  a_r1_idle_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> tx_bit);

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r4_start_dominant: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !tx_bit);

  a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !req_ready) |=> $stable(tx_bit));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  a_r7_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> req_ready);

  a_r2_ready_return_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> tx_done);
endmodule

bind ser_frame_tx ser_frame_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .bit_en(bit_en), .tx_bit(tx_bit), .tx_done(tx_done)
);

// File: tb/tb_ser_frame_tx.sv
`timescale 1ns/1ps
module tb_ser_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [10:0] req_id = '0;
  logic        req_rtr = 1'b0;
  logic [1:0]  req_len = '0;
  logic [15:0] req_data = '0;
  logic        bit_en = 1'b0;
  logic        tx_bit, tx_done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int en_period = 1;
  int en_cnt = 0;
  bit en_force_idle = 1'b0;

  // reference model state
  bit     m_busy = 1'b0;
  bit     m_done = 1'b0;
  bit     m_q[$];
  bit     m_frame[$];
  bit     cap_q[$];

  always #2 clk = ~clk;  // 250 MHz

  ser_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_rtr(req_rtr), .req_len(req_len), .req_data(req_data),
    .bit_en(bit_en), .tx_bit(tx_bit), .tx_done(tx_done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic void make_frame(input logic [10:0] id, input logic rtr,
                                     input logic [1:0] len, input logic [15:0] data);
    int ones;
    m_frame = {};
    m_frame.push_back(1'b0);
    for (int i = 10; i >= 0; i--) m_frame.push_back(id[i]);
    m_frame.push_back(rtr);
    m_frame.push_back(1'b0);
    m_frame.push_back(1'b0);
    for (int i = 1; i >= 0; i--) m_frame.push_back(len[i]);
    for (int i = 15; i >= 0; i--) m_frame.push_back(data[i]);
    ones = 0;
    foreach (m_frame[k]) ones += int'(m_frame[k]);
    m_frame.push_back(bit'(ones % 2));
    for (int i = 0; i < 10; i++) m_frame.push_back(1'b1);
  endfunction

  // reference model and capture of the DUT line at each tick
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_q = {};
    end else begin
      if (bit_en && !req_ready) cap_q.push_back(tx_bit);
      if (req_valid && req_ready) cap_q = {};
      m_done = 1'b0;
      if (m_busy) begin
        if (bit_en) begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) begin m_busy = 1'b0; m_done = 1'b1; end
        end
      end else if (req_valid) begin
        make_frame(req_id, req_rtr, req_len, req_data);
        m_q = m_frame;
        m_busy = 1'b1;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == !m_busy, "R2 ready", req_ready, !m_busy);
      chk(tx_bit == (m_busy ? m_q[0] : 1'b1), "R4/R6 tx_bit", tx_bit, m_busy ? m_q[0] : 1'b1);
      chk(tx_done == m_done, "R7 done", tx_done, m_done);
    end
  end

  // tick generator
  always @(negedge clk) begin
    en_cnt = en_cnt + 1;
    bit_en <= en_force_idle || (en_period > 0 && (en_cnt % en_period) == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic present(input logic [10:0] id, input logic rtr,
                         input logic [1:0] len, input logic [15:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_id = id; req_rtr = rtr; req_len = len; req_data = data;
  endtask

  task automatic wait_accept();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!tx_done && guard < 2000) begin @(negedge clk); guard++; end
  endtask

  task automatic check_frame(input string tag, input logic [10:0] id, input logic rtr,
                             input logic [1:0] len, input logic [15:0] data);
    bit same;
    make_frame(id, rtr, len, data);
    chk(cap_q.size() == 44, {tag, " length"}, cap_q.size(), 44);
    same = (cap_q.size() == m_frame.size());
    if (same) foreach (m_frame[k]) if (cap_q[k] != m_frame[k]) same = 0;
    chk(same, {tag, " content"}, same, 1);
  endtask

  initial begin
    int par, run, best;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && tx_bit == 1'b1 && tx_done == 1'b0, "R1 reset state",
        {req_ready, tx_bit, tx_done}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && tx_bit == 1'b1, "R1 idle after reset", {req_ready, tx_bit}, 2'b11);

    // R3 R4: dense ticks
    en_period = 1;
    present(11'h5A3, 1'b0, 2'd2, 16'hBEEF);
    wait_accept();
    wait_done();
    check_frame("R3 R4 frame A", 11'h5A3, 1'b0, 2'd2, 16'hBEEF);
    par = 0;
    for (int k = 0; k < 34 && k < cap_q.size(); k++) par ^= int'(cap_q[k]);
    chk(par == 0, "R5 parity even", par, 0);

    // R6 R8: sparse ticks, request held and changed while busy
    en_period = 3;
    present(11'h0F0, 1'b1, 2'd1, 16'h1234);
    wait_accept();
    present(11'h7FF, 1'b0, 2'd3, 16'h0001);
    repeat (20) @(negedge clk);
    req_id = 11'h2C5; req_data = 16'hA55A;
    wait_done();
    check_frame("R6 R8 frame B", 11'h0F0, 1'b1, 2'd1, 16'h1234);
    wait_accept();
    wait_done();
    check_frame("R8 held frame C", 11'h2C5, 1'b0, 2'd3, 16'hA55A);

    // R9: ticks while idle
    en_period = 0;
    en_force_idle = 1'b1;
    repeat (6) @(negedge clk);
    chk(tx_bit == 1'b1 && req_ready == 1'b1, "R9 idle ticks", {tx_bit, req_ready}, 2'b11);
    en_force_idle = 1'b0;

    // R10: all-zero request, no stuffing
    en_period = 2;
    present(11'h000, 1'b0, 2'd0, 16'h0000);
    wait_accept();
    wait_done();
    check_frame("R10 zero frame", 11'h000, 1'b0, 2'd0, 16'h0000);
    run = 0; best = 0;
    foreach (cap_q[k]) begin
      if (!cap_q[k]) begin run++; if (run > best) best = run; end else run = 0;
    end
    chk(best == 34, "R10 zero run", best, 34);

    // R5: all-ones fields, parity bit 0
    en_period = 1;
    present(11'h7FF, 1'b1, 2'd3, 16'hFFFF);
    wait_accept();
    wait_done();
    check_frame("R5 ones frame", 11'h7FF, 1'b1, 2'd3, 16'hFFFF);
    chk(cap_q.size() > 33 && cap_q[33] == 1'b0, "R5 parity bit", cap_q.size() > 33 ? cap_q[33] : 1'b1, 0);

    // R7: done pulse is single
    @(negedge clk);
    chk(tx_done == 1'b0 && req_ready == 1'b1, "R7 done single", {tx_done, req_ready}, 2'b01);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule